// File: doc/BRIEF.md
# UART Processor Register Bank with Prioritised Interrupts

This block is the part of a UART that the host processor sees. It decodes a 3-bit register address qualified by a chip select and separate read and write strobes. It holds the writable configuration registers: line control, modem control, interrupt enable, scratch, and the two bytes of the baud divisor. It also holds the transmit holding byte and the latched receive byte. From these it derives the line status and interrupt identification values.

The serial shifters are not part of this block. Each one appears only as a few flag pins. The receiver pushes a finished byte in with a one-cycle strobe. The transmitter reports that it has taken the holding byte, and whether its shifter is idle. In return the block gives the transmitter each newly written byte with a one-cycle load pulse, and gives both shifters the divisor and the line control settings.

The four modem control pins are active-low. They go inactive while reset is applied and whenever the loopback bit is set. The interrupt identification value is encoded by priority: received data first, then transmit-empty, then "nothing pending". Reads return data one cycle after the strobe, on a registered output.

Top module: `uart_regbank`

## Requirements
- R1: After synchronous reset, the line control, modem control, interrupt enable, scratch and both divisor bytes all read 0x00.
- R2: Every register in R1 reads back exactly the last byte written to it.
- R3: With line control bit 7 set, address 0 reaches the divisor low byte and address 1 reaches the divisor high byte, and `divisor` equals {high, low}. With bit 7 clear, address 0 reaches the receive byte (read) or the transmit holding byte (write), and address 1 reaches the interrupt enable register.
- R4: One cycle after modem control changes, `dtr_n`, `rts_n`, `out1_n` and `out2_n` equal the inverse of modem control bits 0, 1, 2 and 3.
- R5: While reset is high, and one cycle after modem control bit 4 (loopback) becomes 1, all four modem pins are 1.
- R6: Line status (address 5) has data ready in bit 0, holding-register empty in bit 5, and transmitter empty (= bit 5 AND `tx_idle`) in bit 6. All other bits read 0. After reset, with `tx_idle` high, it reads 0x60.
- R7: Interrupt identification (address 2) reads 0x04 when data is ready and interrupt enable bit 0 is set. Otherwise it reads 0x02 when a transmit-empty interrupt is pending. Otherwise it reads 0x01.
- R8: A transmit-empty interrupt becomes pending when (holding empty AND interrupt enable bit 1) goes from false to true. Reading address 2 while it reports 0x02 clears the pending state. Reading it while it reports 0x04 does not.
- R9: A `rx_push` strobe latches `rx_byte` and sets data ready. Reading address 0 with bit 7 of line control clear returns that byte and clears data ready.
- R10: Writing address 0 with line control bit 7 clear clears holding-register empty and produces a one-cycle `tx_load` pulse, with `tx_data` equal to the written byte. A `tx_taken` strobe sets holding-register empty again.
- R11: `irq` is 1 exactly when interrupt identification bit 0 is 0.
- R12: Writing address 0 while line control bit 7 is set produces no `tx_load` pulse and leaves holding-register empty unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe (qualified by cs) |
| wr | input | 1 | Write strobe (qualified by cs, wins over rd) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after the read strobe |
| rx_byte | input | 8 | Byte from the receiver |
| rx_push | input | 1 | One-cycle strobe: rx_byte is valid |
| tx_taken | input | 1 | One-cycle strobe: transmitter took the holding byte |
| tx_idle | input | 1 | Transmit shifter is idle |
| tx_data | output | 8 | Holding byte for the transmitter |
| tx_load | output | 1 | One-cycle pulse after a holding-register write |
| divisor | output | 16 | Baud divisor {high, low} |
| line_ctrl | output | 8 | Line control register contents |
| irq | output | 1 | Interrupt request |
| dtr_n | output | 1 | Modem control pin 0, active-low |
| rts_n | output | 1 | Modem control pin 1, active-low |
| out1_n | output | 1 | Modem control pin 2, active-low |
| out2_n | output | 1 | Modem control pin 3, active-low |

## Verification
Addresses 0 and 1 are exercised with line control bit 7 both set and clear, using distinct bytes in the divisor, enable and data registers. This shows that the access switch routes to the right storage in both directions. The modem pins are driven with four bit patterns that separate the individual pins, then with loopback set over both all-ones and mixed values, so that the inversion and the forcing can be told apart. The interrupt sequence arms transmit-empty, then lets received data overlap it, then acknowledges in both orders. This separates priority from the clearing rules, including the rule that a pending transmit-empty condition survives a read that reported received data.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int MODEM_N  = 4;
  localparam int DLAB_BIT = 7;
  localparam int LOOP_BIT = 4;

  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_IID   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LCTL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_MSTAT = 3'd6;
  localparam logic [ADDR_W-1:0] A_SCR   = 3'd7;

  localparam logic [DATA_W-1:0] IID_NONE = 8'h01;
  localparam logic [DATA_W-1:0] IID_THRE = 8'h02;
  localparam logic [DATA_W-1:0] IID_RDA  = 8'h04;
endpackage

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
  import uart_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_push,
  input  logic              tx_taken,
  output logic [DATA_W-1:0] lcr,
  output logic [DATA_W-1:0] mcr,
  output logic [DATA_W-1:0] ier,
  output logic [DATA_W-1:0] scr,
  output logic [DATA_W-1:0] dll,
  output logic [DATA_W-1:0] dlm,
  output logic [DATA_W-1:0] rbr,
  output logic [DATA_W-1:0] thr,
  output logic              tx_load,
  output logic              thre,
  output logic              dr
);
  logic dlab;
  logic thr_wr;
  logic rbr_rd;

  assign dlab   = lcr[DLAB_BIT];
  assign thr_wr = wr_en && (addr == A_DATA) && !dlab;
  assign rbr_rd = rd_en && (addr == A_DATA) && !dlab;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr <= '0; mcr <= '0; ier <= '0; scr <= '0;
      dll <= '0; dlm <= '0; thr <= '0; tx_load <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_DATA: begin
            if (dlab) dll <= wdata;
            else begin
              thr     <= wdata;
              tx_load <= 1'b1;
            end
          end
          A_IEN: begin
            if (dlab) dlm <= wdata;
            else      ier <= wdata;
          end
          A_LCTL:  lcr <= wdata;
          A_MCTL:  mcr <= wdata;
          A_SCR:   scr <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thre <= 1'b1;
      dr   <= 1'b0;
      rbr  <= '0;
    end else begin
      if (thr_wr)        thre <= 1'b0;
      else if (tx_taken) thre <= 1'b1;
      if (rx_push) begin
        dr  <= 1'b1;
        rbr <= rx_byte;
      end else if (rbr_rd) begin
        dr  <= 1'b0;
      end
    end
  end

  assert_thr_write_clears_R10: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> !thre);
  assert_rbr_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (rbr_rd && !rx_push) |=> !dr);
  assert_reset_flags_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (thre && !dr));
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
  import uart_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_rda,
  input  logic              en_thre,
  input  logic              thre,
  input  logic              dr,
  input  logic              iid_read,
  output logic [DATA_W-1:0] iid,
  output logic              irq
);
  logic rda;
  logic tx_cond;
  logic cond_q;
  logic pend;

  assign rda     = en_rda && dr;
  assign tx_cond = en_thre && thre;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      cond_q <= tx_cond;
      if (!tx_cond)                    pend <= 1'b0;
      else if (!cond_q)                pend <= 1'b1;
      else if (iid_read && !rda)       pend <= 1'b0;
    end
  end

  always_comb begin
    if (rda)       iid = IID_RDA;
    else if (pend) iid = IID_THRE;
    else           iid = IID_NONE;
  end

  assign irq = rda || pend;

  assert_iid_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (iid_read && iid == IID_THRE) |=> (iid != IID_THRE));
  assert_rda_holds_pend_R8: assert property (@(posedge clk) disable iff (rst)
    (iid_read && rda && pend && tx_cond) |=> pend);
endmodule

// File: rtl/uart_rb_modem.sv
module uart_rb_modem
  import uart_rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [LOOP_BIT:0]  mcr,
  output logic [MODEM_N-1:0] pins_n
);
  for (genvar i = 0; i < MODEM_N; i++) begin : g_pin
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b1;
      else     q <= ~mcr[i] | mcr[LOOP_BIT];
    end
    assign pins_n[i] = q;
  end

  assert_loop_idle_R5: assert property (@(posedge clk) disable iff (rst)
    mcr[LOOP_BIT] |=> (&pins_n));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        rx_byte,
  input  logic              rx_push,
  input  logic              tx_taken,
  input  logic              tx_idle,
  output logic [7:0]        tx_data,
  output logic              tx_load,
  output logic [15:0]       divisor,
  output logic [7:0]        line_ctrl,
  output logic              irq,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n
);
  logic wr_en, rd_en;
  logic [DATA_W-1:0] lcr, mcr, ier, scr, dll, dlm, rbr, thr, iid, lsr;
  logic thre, dr;
  logic [MODEM_N-1:0] pins_n;

  assign wr_en = cs && wr;
  assign rd_en = cs && rd && !wr;

  uart_rb_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rx_byte(rx_byte), .rx_push(rx_push), .tx_taken(tx_taken),
    .lcr(lcr), .mcr(mcr), .ier(ier), .scr(scr), .dll(dll), .dlm(dlm),
    .rbr(rbr), .thr(thr), .tx_load(tx_load), .thre(thre), .dr(dr)
  );

  uart_rb_irq u_irq (
    .clk(clk), .rst(rst), .en_rda(ier[0]), .en_thre(ier[1]),
    .thre(thre), .dr(dr), .iid_read(rd_en && addr == A_IID),
    .iid(iid), .irq(irq)
  );

  uart_rb_modem u_modem (
    .clk(clk), .rst(rst), .mcr(mcr[LOOP_BIT:0]), .pins_n(pins_n)
  );

  assign lsr       = {1'b0, thre && tx_idle, thre, 4'b0000, dr};
  assign tx_data   = thr;
  assign divisor   = {dlm, dll};
  assign line_ctrl = lcr;
  assign dtr_n     = pins_n[0];
  assign rts_n     = pins_n[1];
  assign out1_n    = pins_n[2];
  assign out2_n    = pins_n[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_DATA:  rdata <= lcr[DLAB_BIT] ? dll : rbr;
        A_IEN:   rdata <= lcr[DLAB_BIT] ? dlm : ier;
        A_IID:   rdata <= iid;
        A_LCTL:  rdata <= lcr;
        A_MCTL:  rdata <= mcr;
        A_LSTAT: rdata <= lsr;
        A_MSTAT: rdata <= '0;
        default: rdata <= scr;
      endcase
    end
  end

  assert_dlab_write_no_load_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DATA && line_ctrl[DLAB_BIT]) |=> !tx_load);
endmodule

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata, rx_byte = '0, tx_data, line_ctrl;
  logic rx_push = 0, tx_taken = 0, tx_idle = 1, tx_load, irq;
  logic [15:0] divisor;
  logic dtr_n, rts_n, out1_n, out2_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_regbank uut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .rx_push(rx_push),
    .tx_taken(tx_taken), .tx_idle(tx_idle), .tx_data(tx_data),
    .tx_load(tx_load), .divisor(divisor), .line_ctrl(line_ctrl), .irq(irq),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(a, v);
    chk(req, {8'h00, v}, {8'h00, exp});
  endtask

  function automatic logic [3:0] pins();
    return {out2_n, out1_n, rts_n, dtr_n};
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R5 pins in reset", {12'h0, pins()}, 16'h000f);
    rst = 0;
    @(negedge clk);
    rd_chk("R1 lcr", 3'd3, 8'h00);
    rd_chk("R1 mcr", 3'd4, 8'h00);
    rd_chk("R1 ier", 3'd1, 8'h00);
    rd_chk("R1 scr", 3'd7, 8'h00);
    rd_chk("R6 lsr after reset", 3'd5, 8'h60);
    rd_chk("R7 iid idle", 3'd2, 8'h01);
    chk("R11 irq idle", {15'h0, irq}, 16'h0000);
    wr_reg(3'd3, 8'h80);
    rd_chk("R1 dll", 3'd0, 8'h00);
    rd_chk("R1 dlm", 3'd1, 8'h00);
    wr_reg(3'd3, 8'h00);
  endtask

  task automatic t_readback();
    wr_reg(3'd3, 8'h1b); rd_chk("R2 lcr", 3'd3, 8'h1b);
    chk("R2 line_ctrl port", {8'h0, line_ctrl}, 16'h001b);
    wr_reg(3'd7, 8'h5a); rd_chk("R2 scr", 3'd7, 8'h5a);
    wr_reg(3'd7, 8'hc3); rd_chk("R2 scr second", 3'd7, 8'hc3);
    wr_reg(3'd1, 8'ha4); rd_chk("R2 ier", 3'd1, 8'ha4);
    wr_reg(3'd4, 8'he8); rd_chk("R2 mcr", 3'd4, 8'he8);
    wr_reg(3'd1, 8'h00); wr_reg(3'd4, 8'h00);
    wr_reg(3'd3, 8'h83);
    wr_reg(3'd0, 8'h34);
    chk("R12 no load on dll write", {15'h0, tx_load}, 16'h0000);
    wr_reg(3'd1, 8'h12);
    chk("R3 divisor", divisor, 16'h1234);
    rd_chk("R3 dll", 3'd0, 8'h34);
    rd_chk("R3 dlm", 3'd1, 8'h12);
    rd_chk("R12 thre kept", 3'd5, 8'h60);
    wr_reg(3'd3, 8'h03);
    rd_chk("R3 addr1 is ier", 3'd1, 8'h00);
    rd_chk("R3 addr0 is rbr", 3'd0, 8'h00);
    chk("R3 divisor kept", divisor, 16'h1234);
  endtask

  task automatic t_modem();
    logic [7:0] pat [4] = '{8'h00, 8'h05, 8'h0a, 8'h0f};
    for (int i = 0; i < 4; i++) begin
      wr_reg(3'd4, pat[i]);
      @(negedge clk);
      chk("R4 modem pins", {12'h0, pins()}, {12'h0, ~pat[i][3:0]});
    end
    wr_reg(3'd4, 8'h1f); @(negedge clk);
    chk("R5 loopback all set", {12'h0, pins()}, 16'h000f);
    wr_reg(3'd4, 8'h13); @(negedge clk);
    chk("R5 loopback mixed", {12'h0, pins()}, 16'h000f);
    wr_reg(3'd4, 8'h03); @(negedge clk);
    chk("R4 after loopback", {12'h0, pins()}, 16'h000c);
    wr_reg(3'd4, 8'h00);
  endtask

  task automatic t_tx();
    wr_reg(3'd0, 8'h96);
    chk("R10 load pulse", {15'h0, tx_load}, 16'h0001);
    chk("R10 tx_data", {8'h0, tx_data}, 16'h0096);
    @(negedge clk);
    chk("R10 load one cycle", {15'h0, tx_load}, 16'h0000);
    rd_chk("R10 thre cleared", 3'd5, 8'h00);
    @(negedge clk); tx_taken = 1; @(negedge clk); tx_taken = 0;
    rd_chk("R10 thre set by taken", 3'd5, 8'h60);
    tx_idle = 0;
    rd_chk("R6 temt follows idle", 3'd5, 8'h20);
    tx_idle = 1;
  endtask

  task automatic t_rx();
    @(negedge clk); rx_byte = 8'h3c; rx_push = 1; @(negedge clk); rx_push = 0;
    rd_chk("R9 dr set", 3'd5, 8'h61);
    rd_chk("R9 rbr data", 3'd0, 8'h3c);
    rd_chk("R9 dr cleared", 3'd5, 8'h60);
  endtask

  task automatic t_irq();
    wr_reg(3'd1, 8'h02); @(negedge clk);
    chk("R11 irq on thre", {15'h0, irq}, 16'h0001);
    rd_chk("R7 iid thre", 3'd2, 8'h02);
    rd_chk("R8 acked", 3'd2, 8'h01);
    chk("R11 irq after ack", {15'h0, irq}, 16'h0000);
    wr_reg(3'd0, 8'h55);
    @(negedge clk); tx_taken = 1; @(negedge clk); tx_taken = 0;
    @(negedge clk);
    wr_reg(3'd1, 8'h03);
    @(negedge clk); rx_byte = 8'ha7; rx_push = 1; @(negedge clk); rx_push = 0;
    rd_chk("R7 rda priority", 3'd2, 8'h04);
    chk("R11 irq on rda", {15'h0, irq}, 16'h0001);
    rd_chk("R9 rbr second", 3'd0, 8'ha7);
    rd_chk("R8 thre survives rda read", 3'd2, 8'h02);
    rd_chk("R8 cleared after ack", 3'd2, 8'h01);
    wr_reg(3'd1, 8'h00);
    chk("R11 irq disabled", {15'h0, irq}, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_readback();
    t_modem();
    t_tx();
    t_rx();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule